// File: doc/BRIEF.md
# Clock Output Pin and Alarm Interrupt Controller

This block sits beside the timekeeping core of a real-time clock. It holds an 8-bit control register that a host writes and reads through a simple parallel port. It drives a single active-low, open-drain style pin, and it tells the crystal oscillator whether to run. The pin carries one of two things. In square-wave mode it carries a wave whose rate is taken from a free-running 15-bit divider, which advances on a 32.768 kHz clock-enable tick. In interrupt mode it carries the alarm flags from the status register, each gated by its own enable bit.

A separate enable bit decides whether the pin may assert while the chip runs from its backup supply. Oscillator control is inverted: a set bit stops the oscillator. While the oscillator is stopped, the divider freezes and ticks are ignored.

Top module: `rtcpin_top`

## Requirements
- R1: While reset is low, and directly after reset, the register reads 0x18, `oscRun` is 1 and the pin is released (`pinDrive` 0, `pinLevel` 1).
- R2: A write lands on the clock edge where `wrEn` is high and is visible on `rdData` after that edge. Bit 6 ignores writes and always reads 0.
- R3: `oscRun` is the inverse of register bit 7.
- R4: With bit 2 = 0 (square-wave mode), bits 4:3 select the source. 00 selects divider bit 14 (1 Hz), 01 selects divider bit 2 (4.096 kHz), 10 selects divider bit 1 (8.192 kHz) and 11 selects the tick itself (32.768 kHz). A source value of 1 releases the pin and 0 drives it, one cycle after the sampled state.
- R5: While bit 7 is 1, the divider holds its value and ticks have no effect on it or on the pin.
- R6: With bit 2 = 1 (interrupt mode), the pin is driven one cycle later exactly when (`alarmFlag[0]` and bit 0) or (`alarmFlag[1]` and bit 1).
- R7: In square-wave mode, the alarm flags have no effect on the pin.
- R8: While `onBackup` is 1 and bit 5 is 0, the pin is released one cycle later. With bit 5 = 1, the pin behaves normally on backup power.
- R9: Changing bits 4:3 does not reset the divider. The new source is taken from the running count.
- R10: `pinLevel` is always the inverse of `pinDrive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| tick32k | input | 1 | One-cycle clock enable at 32.768 kHz |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Current register contents |
| alarmFlag | input | 2 | Alarm flags; bit 0 alarm 1, bit 1 alarm 2 |
| onBackup | input | 1 | High while running from backup supply |
| oscRun | output | 1 | High when the oscillator should run |
| pinDrive | output | 1 | High when the pin is pulled low |
| pinLevel | output | 1 | Resolved pin level (1 released, 0 driven) |

## Verification
`rdData` and `oscRun` change on the edge that takes a write. `pinDrive` is registered, so it reflects register contents, divider count, tick, flags and backup state from the cycle before that edge. The divider itself advances on the edge where a gated tick is seen. The bench drives inputs on the falling edge and samples just after the rising edge. It updates its reference register, divider and pin prediction from the pre-edge values only, so every comparison falls in the cycle where the result is due.

// File: rtl/rtcpin_pkg.sv
package rtcpin_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_ALARMS = 2;

  // Bit positions the pin logic decodes
  localparam int B_OSC_OFF = 7;
  localparam int B_SPARE   = 6;
  localparam int B_BACKUP  = 5;
  localparam int B_RATE_HI = 4;
  localparam int B_RATE_LO = 3;
  localparam int B_INTMODE = 2;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'b00,
    RATE_MID  = 2'b01,
    RATE_FAST = 2'b10,
    RATE_TICK = 2'b11
  } rateSel_t;

  typedef struct packed {
    logic                  oscEn;
    logic                  backupEn;
    rateSel_t              rate;
    logic                  intMode;
    logic [NUM_ALARMS-1:0] alarmEn;
  } ctlStrobe_t;
endpackage

// File: rtl/rtcpin_ctrl.sv
module rtcpin_ctrl
  import rtcpin_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_VAL = 8'h18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] regQ,
  output ctlStrobe_t       strobe
);
  localparam logic [REG_W-1:0] KEEP_MASK = ~(REG_W'(1) << B_SPARE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     regQ <= RESET_VAL & KEEP_MASK;
    else if (wrEn) regQ <= wrData & KEEP_MASK;
  end

  always_comb begin
    strobe.oscEn    = ~regQ[B_OSC_OFF];
    strobe.backupEn = regQ[B_BACKUP];
    strobe.rate     = rateSel_t'(regQ[B_RATE_HI:B_RATE_LO]);
    strobe.intMode  = regQ[B_INTMODE];
    strobe.alarmEn  = regQ[NUM_ALARMS-1:0];
  end
endmodule

// File: rtl/rtcpin_path.sv
module rtcpin_path
  import rtcpin_pkg::*;
#(
  parameter int DIV_W    = 15,
  parameter int TAP_FAST = 1,
  parameter int TAP_MID  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick32k,
  input  logic [NUM_ALARMS-1:0] alarmFlag,
  input  logic                  onBackup,
  input  ctlStrobe_t            strobe,
  output logic                  pinDrive
);
  localparam int TAP_SLOW = DIV_W - 1;

  logic [DIV_W-1:0]      divQ;
  logic                  tickGated;
  logic                  waveHigh;
  logic [NUM_ALARMS-1:0] alarmHit;
  logic                  wantDrive;
  logic                  pinAllowed;

  assign tickGated = tick32k & strobe.oscEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          divQ <= '0;
    else if (tickGated) divQ <= divQ + 1'b1;
  end

  always_comb begin
    unique case (strobe.rate)
      RATE_SLOW: waveHigh = divQ[TAP_SLOW];
      RATE_MID:  waveHigh = divQ[TAP_MID];
      RATE_FAST: waveHigh = divQ[TAP_FAST];
      default:   waveHigh = tickGated;
    endcase
  end

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : gAlarm
    assign alarmHit[g] = alarmFlag[g] & strobe.alarmEn[g];
  end

  assign pinAllowed = ~onBackup | strobe.backupEn;
  assign wantDrive  = strobe.intMode ? |alarmHit : ~waveHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinDrive <= 1'b0;
    else       pinDrive <= wantDrive & pinAllowed;
  end
endmodule

// File: rtl/rtcpin_top.sv
module rtcpin_top
  import rtcpin_pkg::*;
#(
  parameter int               DIV_W     = 15,
  parameter logic [REG_W-1:0] RESET_VAL = 8'h18
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick32k,
  input  logic                  wrEn,
  input  logic [REG_W-1:0]      wrData,
  output logic [REG_W-1:0]      rdData,
  input  logic [NUM_ALARMS-1:0] alarmFlag,
  input  logic                  onBackup,
  output logic                  oscRun,
  output logic                  pinDrive,
  output logic                  pinLevel
);
  ctlStrobe_t strobe;

  rtcpin_ctrl #(.RESET_VAL(RESET_VAL)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .regQ(rdData), .strobe(strobe)
  );

  rtcpin_path #(.DIV_W(DIV_W)) u_path (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .alarmFlag(alarmFlag),
    .onBackup(onBackup), .strobe(strobe), .pinDrive(pinDrive)
  );

  assign oscRun   = strobe.oscEn;
  assign pinLevel = ~pinDrive;
endmodule

// File: rtl/rtcpin_check.sv
module rtcpin_check (
  input logic       clk,
  input logic       rstN,
  input logic       tick32k,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [1:0] alarmFlag,
  input logic       onBackup,
  input logic       pinDrive
);
  logic muted, hit;
  assign muted = onBackup & ~rdData[5];
  assign hit   = (alarmFlag[0] & rdData[0]) | (alarmFlag[1] & rdData[1]);

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == {$past(wrData[7]), 1'b0, $past(wrData[5:0])});

  a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[6]);

  a_r8_backup_mute: assert property (@(posedge clk) disable iff (!rstN)
    muted |=> !pinDrive);

  a_r6_int_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[2] && !hit) |=> !pinDrive);

  a_r6_int_fire: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[2] && hit && !muted) |=> pinDrive);

  a_r5_stopped_tick: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[7] && !rdData[2] && rdData[4:3] == 2'b11 && !muted) |=> pinDrive);

  a_r4_tick_release: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[7] && !rdData[2] && rdData[4:3] == 2'b11 && tick32k) |=> !pinDrive);
endmodule

bind rtcpin_top rtcpin_check u_rtcpin_check (
  .clk(clk), .rstN(rstN), .tick32k(tick32k), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .alarmFlag(alarmFlag), .onBackup(onBackup), .pinDrive(pinDrive)
);

// File: tb/test_rtcpin_top.sv
module test_rtcpin_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick32k = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [1:0] alarmFlag = 2'b00;
  logic       onBackup = 1'b0;
  logic       oscRun, pinDrive, pinLevel;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0]  mReg;
  logic [14:0] mDiv;
  logic        mPin;

  always #2 clk = ~clk;

  rtcpin_top i_rtcpin_top (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .alarmFlag(alarmFlag), .onBackup(onBackup),
    .oscRun(oscRun), .pinDrive(pinDrive), .pinLevel(pinLevel)
  );

  function automatic logic predictPin(logic [7:0] r, logic [14:0] d, logic t,
                                      logic [1:0] f, logic bk);
    logic src;
    if (bk && !r[5]) return 1'b0;                                   // R8
    if (r[2]) return (f[0] & r[0]) | (f[1] & r[1]);                 // R6
    case (r[4:3])                                                   // R4, R7
      2'b00:   src = d[14];
      2'b01:   src = d[2];
      2'b10:   src = d[1];
      default: src = t & ~r[7];                                     // R5
    endcase
    return ~src;
  endfunction

  function automatic string pinTag(logic [7:0] r, logic bk);
    if (bk && !r[5]) return "R8";
    if (r[2])        return "R6";
    if (r[7])        return "R5";
    return "R4";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, update model from pre-edge state, sample after rising edge
  task automatic step(logic t, logic w, logic [7:0] wd, logic [1:0] f, logic bk, string ctx);
    string tag;
    @(negedge clk);
    tick32k = t; wrEn = w; wrData = wd; alarmFlag = f; onBackup = bk;
    tag  = pinTag(mReg, bk);
    mPin = predictPin(mReg, mDiv, t, f, bk);
    if (t && !mReg[7]) mDiv = mDiv + 1'b1;
    if (w) mReg = {wd[7], 1'b0, wd[5:0]};
    @(posedge clk); #1;
    check(pinDrive === mPin, {tag, " ", ctx}, pinDrive, mPin);
    check(rdData === mReg, {"R2 ", ctx}, rdData, mReg);
    check(oscRun === ~mReg[7], {"R3 ", ctx}, oscRun, ~mReg[7]);
    check(pinLevel === ~pinDrive, {"R10 ", ctx}, pinLevel, ~pinDrive);
  endtask

  task automatic idle(int n, logic t, logic [1:0] f, logic bk, string ctx);
    for (int i = 0; i < n; i++) step(t, 1'b0, 8'h00, f, bk, ctx);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    check(rdData === 8'h18, "R1 reset reg", rdData, 8'h18);
    check(oscRun === 1'b1, "R1 reset osc", oscRun, 1);
    check(pinDrive === 1'b0, "R1 reset pin", pinDrive, 0);
    check(pinLevel === 1'b1, "R1 reset level", pinLevel, 1);
    mReg = 8'h18; mDiv = '0; mPin = 1'b0;
    @(negedge clk); rstN = 1'b1;

    // R2: spare bit 6 ignores writes
    step(1'b0, 1'b1, 8'hFF, 2'b00, 1'b0, "spare write");
    check(rdData[6] === 1'b0, "R2 spare bit", rdData, 8'hBF);
    // R6: interrupt mode, walk all flag/enable combinations
    for (int e = 0; e < 4; e++) begin
      step(1'b0, 1'b1, 8'h04 | 8'(e), 2'b00, 1'b0, "R6 en");
      for (int fl = 0; fl < 4; fl++) step(1'b1, 1'b0, 8'h00, 2'(fl), 1'b0, "R6 flags");
    end
    // R8: backup with and without bit 5
    step(1'b0, 1'b1, 8'h07, 2'b11, 1'b1, "R8 muted");
    idle(3, 1'b0, 2'b11, 1'b1, "R8 muted");
    step(1'b0, 1'b1, 8'h27, 2'b11, 1'b1, "R8 allowed");
    idle(3, 1'b0, 2'b11, 1'b1, "R8 allowed");
    // R7: square wave ignores flags; R4 every rate with steady ticks
    for (int r = 0; r < 4; r++) begin
      step(1'b1, 1'b1, 8'(r << 3), 2'b00, 1'b0, "R4 rate");
      for (int i = 0; i < 20; i++) step(1'(i % 2), 1'b0, 8'h00, 2'(i), 1'b0, "R7 flags in wave");
    end
    // R5: stopped oscillator freezes divider
    step(1'b1, 1'b1, 8'h88, 2'b00, 1'b0, "R5 stop");
    idle(40, 1'b1, 2'b00, 1'b0, "R5 frozen");
    step(1'b1, 1'b1, 8'h08, 2'b00, 1'b0, "R5 restart");
    // R9: rate changes mid-count keep the divider
    idle(5, 1'b1, 2'b00, 1'b0, "R9 run");
    step(1'b1, 1'b1, 8'h10, 2'b00, 1'b0, "R9 to fast");
    idle(5, 1'b1, 2'b00, 1'b0, "R9 run");
    step(1'b1, 1'b1, 8'h08, 2'b00, 1'b0, "R9 to mid");
    idle(5, 1'b1, 2'b00, 1'b0, "R9 run");
    // R4: 1 Hz tap across two full half-periods
    step(1'b1, 1'b1, 8'h00, 2'b00, 1'b0, "R4 slow");
    idle(70000, 1'b1, 2'b11, 1'b0, "R4 slow run");
    // Constrained random mix
    for (int i = 0; i < 30000; i++) begin
      logic w;
      logic [7:0] d;
      w = ($urandom % 48) == 0;
      d = 8'($urandom);
      if (($urandom % 4) != 0) d[7] = 1'b0;
      step(1'($urandom % 2), w, d, 2'($urandom), 1'(($urandom % 5) == 0), "random");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule